// File: doc/BRIEF.md
# 16-Bit Timer/Event Counter with Compare

This block is a 16-bit up-counter with one compare register. It runs in one of two modes. In the first, the count returns to zero when it reaches the compare value. In the second, the count runs freely and wraps. The counter advances on a selectable count tick, which is one of the following:
- every system clock;
- one of two taps of a free-running prescaler;
- the rising edge of an external event input, which the block synchronises internally.

The block has four outputs: a one-cycle match interrupt, an overflow status bit that flips on every wrap, a timer output pin with a programmable idle level, and the current count.

Software sets up the block through a byte-wide register port. The map is:

| Address | Register |
|---|---|
| 0 | control |
| 1 | compare low byte |
| 2 | compare high byte |
| 3 | not used, reads 0 |

Read data is registered. It appears one cycle after the address is presented. The usual flow is to set the compare value and the control fields while the counter is stopped, and then set the run bit.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control register reads 0x00, the count is 0, the overflow bit is 0, match_irq and tmr_out are 0, and the compare register reads 0xFFFF.
- R2: While control bit 7 (run) is 0, the count is held at 0. While it is 1, the count increases by one on each count tick, unless R3 applies.
- R3: With control bit 6 (mode) at 0, a count tick that finds the count equal to the compare value loads 0. The counter therefore repeats 0 through the compare value.
- R4: With mode at 1, the counter runs freely and wraps from 0xFFFF to 0x0000.
- R5: match_irq is a one-cycle pulse in the cycle after a count tick that finds count equal to compare with mode 0. It never pulses with mode 1.
- R6: The overflow bit (control read bit 3) inverts on every wrap in mode 1. It does not change in mode 0.
- R7: Control bits 1:0 select the count tick:
  - 00: every clock.
  - 01: once every 32 clocks, when the low 5 bits of a free-running 7-bit divider (zero at reset) are all ones.
  - 10: once every 128 clocks, when all 7 divider bits are ones.
  - 11: the event input, as described in R10.
- R8: With control bit 5 (output enable) at 0, tmr_out is 0. With it at 1 and run at 0, tmr_out follows control bit 4 (idle level). Both take effect one cycle after the control change.
- R9: With output enable at 1 and run at 1, tmr_out starts from the idle level. It inverts in the cycle after each count tick that finds count equal to compare, in either mode.
- R10: A low-to-high change of ev_in, sampled at clock edge k, produces one count tick that advances the counter at edge k+2. A held level produces no further ticks.
- R11: The register map is: address 0 control, address 1 compare bits 7:0, address 2 compare bits 15:8, address 3 reads 0. reg_rdata shows the addressed register one cycle after the address. Control read bit 2 is always 0, and writes to bits 3 and 2 have no effect.
- R12: A control write while run is 1 changes only bit 7. While run is 0, a write updates all writable fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_in | input | 1 | External event input, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address, used for both reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| cnt_o | output | 16 | Current count |
| match_irq | output | 1 | Compare match interrupt pulse |
| ovf_flag | output | 1 | Overflow status, toggles on each wrap |
| tmr_out | output | 1 | Timer output pin |

## Verification
The bench covers four sets of corner cases:
- **Stopping, clearing and wrapping.** It stops the counter in the middle of a run. It lets the counter wrap twice in free-running mode. A design that cleared the overflow bit instead of toggling it, or that counted wraps in clear-on-match mode, would show a wrong bit 3.
- **Register writes.** It writes control while the counter is running, and it writes the read-only bits. A design that let such a write change the mode, the clock select or the overflow bit would read back the wrong control value and count on the wrong tick.
- **Event path latency.** It steps the event input through a single edge and then through held levels. Losing a synchroniser stage would move the first increment one cycle early. Counting levels instead of edges would run the count too high.
- **Output pin.** It checks the idle level, the disabled state, and toggling on compare in both modes against a cycle-by-cycle reference model, so an off-by-one in the toggle timing is seen.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;

  typedef enum logic [1:0] {
    CS_SYS   = 2'b00,
    CS_DIV_A = 2'b01,
    CS_DIV_B = 2'b10,
    CS_EVENT = 2'b11
  } clk_sel_e;

  typedef struct packed {
    logic     run;
    logic     freerun;
    logic     out_en;
    logic     out_lvl;
    clk_sel_e clk_sel;
  } tmr_ctrl_t;

  localparam int CTRL_ADDR = 0;

endpackage

// File: rtl/evt_tick_gen.sv
module evt_tick_gen
  import evt_timer16_pkg::*;
#(
  parameter int DIV_W  = 7,
  parameter int TAP_A  = 5,
  parameter int TAP_B  = 7,
  parameter int SYNC_N = 2
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     ev_in,
  input  clk_sel_e sel,
  output logic     tick
);

  localparam logic [DIV_W-1:0] DIV_ONE = {{(DIV_W-1){1'b0}}, 1'b1};

  logic [DIV_W-1:0]  div_q;
  logic [SYNC_N-1:0] sync_q;
  logic              ev_prev_q;
  logic              ev_rise;
  logic              tap_a;
  logic              tap_b;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + DIV_ONE;
  end

  assign tap_a = &div_q[TAP_A-1:0];
  assign tap_b = &div_q[TAP_B-1:0];

  for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ev_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ev_prev_q <= 1'b0;
    else     ev_prev_q <= sync_q[SYNC_N-1];
  end

  assign ev_rise = sync_q[SYNC_N-1] & ~ev_prev_q;

  always_comb begin
    unique case (sel)
      CS_SYS:   tick = 1'b1;
      CS_DIV_A: tick = tap_a;
      CS_DIV_B: tick = tap_b;
      default:  tick = ev_rise;
    endcase
  end

endmodule

// File: rtl/evt_ctrl_regs.sv
module evt_ctrl_regs
  import evt_timer16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              ovf,
  output tmr_ctrl_t         ctrl,
  output logic [CNT_W-1:0]  cmp,
  output logic [7:0]        rdata
);

  localparam int CMP_BYTES = CNT_W / 8;

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic             ctrl_sel;

  assign ctrl_sel = we && (addr == ADDR_W'(CTRL_ADDR));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
    end else if (ctrl_sel) begin
      if (!ctrl_q.run) begin
        ctrl_q.run     <= wdata[7];
        ctrl_q.freerun <= wdata[6];
        ctrl_q.out_en  <= wdata[5];
        ctrl_q.out_lvl <= wdata[4];
        ctrl_q.clk_sel <= clk_sel_e'(wdata[1:0]);
      end else begin
        ctrl_q.run <= wdata[7];
      end
    end
  end

  for (genvar b = 0; b < CMP_BYTES; b++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst)
        cmp_q[8*b +: 8] <= 8'hFF;
      else if (we && (addr == ADDR_W'(b + 1)))
        cmp_q[8*b +: 8] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= '0;
      if (addr == ADDR_W'(CTRL_ADDR))
        rdata <= {ctrl_q.run, ctrl_q.freerun, ctrl_q.out_en, ctrl_q.out_lvl,
                  ovf, 1'b0, ctrl_q.clk_sel};
      for (int b = 0; b < CMP_BYTES; b++) begin
        if (addr == ADDR_W'(b + 1)) rdata <= cmp_q[8*b +: 8];
      end
    end
  end

  assign ctrl = ctrl_q;
  assign cmp  = cmp_q;

endmodule

// File: rtl/evt_count_core.sv
module evt_count_core
  import evt_timer16_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_ctrl_t        ctrl,
  input  logic [CNT_W-1:0] cmp,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             ovf,
  output logic             tout
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic             irq_q;
  logic             ovf_q;
  logic             tout_q;
  logic             hit;
  logic             wrap;
  logic             clr;

  assign hit  = (cnt_q == cmp);
  assign wrap = &cnt_q;
  assign clr  = hit && !ctrl.freerun;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      ovf_q  <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!ctrl.run) begin
        cnt_q  <= '0;
        tout_q <= ctrl.out_en & ctrl.out_lvl;
      end else begin
        if (tick) begin
          if (clr) begin
            cnt_q <= '0;
            irq_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + CNT_ONE;
          end
          if (ctrl.freerun && wrap) ovf_q <= ~ovf_q;
        end
        tout_q <= ctrl.out_en ? (tout_q ^ (tick & hit)) : 1'b0;
      end
    end
  end

  assign cnt  = cnt_q;
  assign irq  = irq_q;
  assign ovf  = ovf_q;
  assign tout = tout_q;

endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer16_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 2,
  parameter int DIV_W  = 7,
  parameter int TAP_A  = 5,
  parameter int TAP_B  = 7,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              match_irq,
  output logic              ovf_flag,
  output logic              tmr_out
);

  tmr_ctrl_t        ctrl_q;
  logic [CNT_W-1:0] cmp_q;
  logic             tick;

  evt_ctrl_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (reg_we),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .ovf   (ovf_flag),
    .ctrl  (ctrl_q),
    .cmp   (cmp_q),
    .rdata (reg_rdata)
  );

  evt_tick_gen #(.DIV_W(DIV_W), .TAP_A(TAP_A), .TAP_B(TAP_B), .SYNC_N(SYNC_N)) u_tick (
    .clk   (clk),
    .rst   (rst),
    .ev_in (ev_in),
    .sel   (ctrl_q.clk_sel),
    .tick  (tick)
  );

  evt_count_core #(.CNT_W(CNT_W)) u_core (
    .clk  (clk),
    .rst  (rst),
    .ctrl (ctrl_q),
    .cmp  (cmp_q),
    .tick (tick),
    .cnt  (cnt_o),
    .irq  (match_irq),
    .ovf  (ovf_flag),
    .tout (tmr_out)
  );

endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             freerun,
  input logic             out_en,
  input logic             out_lvl,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             irq,
  input logic             ovf,
  input logic             tout
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r2_stop_zero: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt == '0));

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (run && tick && (cnt != cmp)) |=> (cnt == $past(cnt) + CNT_ONE));

  a_r3_clear: assert property (@(posedge clk) disable iff (rst)
    (run && !freerun && tick && (cnt == cmp)) |=> ((cnt == '0) && irq));

  a_r5_irq_mode0: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run && !freerun && tick));

  a_r6_ovf_hold: assert property (@(posedge clk) disable iff (rst)
    !(run && freerun && tick && (&cnt)) |=> $stable(ovf));

  a_r8_out_off: assert property (@(posedge clk) disable iff (rst)
    !out_en |=> !tout);

  a_r8_idle_level: assert property (@(posedge clk) disable iff (rst)
    (out_en && !run) |=> (tout == $past(out_lvl)));

endmodule

bind evt_timer16 evt_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .run     (ctrl_q.run),
  .freerun (ctrl_q.freerun),
  .out_en  (ctrl_q.out_en),
  .out_lvl (ctrl_q.out_lvl),
  .tick    (tick),
  .cnt     (cnt_o),
  .cmp     (cmp_q),
  .irq     (match_irq),
  .ovf     (ovf_flag),
  .tout    (tmr_out)
);

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ev_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic [15:0] cnt_o;
  logic        match_irq;
  logic        ovf_flag;
  logic        tmr_out;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;
  bit cmp_on = 0;

  // reference model state
  int m_ctrl, m_cmp, m_cnt, m_ovf, m_out, m_irq, m_rdata;
  int m_div, m_s1, m_s2, m_s3;

  evt_timer16 u_evt_timer16 (
    .clk(clk), .rst(rst), .ev_in(ev_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_o(cnt_o),
    .match_irq(match_irq), .ovf_flag(ovf_flag), .tmr_out(tmr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // behavioural reference, evaluated on each rising edge with pre-edge values
  always @(posedge clk) begin
    int tk, hit, run, fr, oe, lv, cs;
    cyc++;
    if (rst) begin
      m_ctrl = 0; m_cmp = 16'hFFFF; m_cnt = 0; m_ovf = 0; m_out = 0;
      m_irq = 0; m_rdata = 0; m_div = 0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
    end else begin
      run = (m_ctrl >> 7) & 1; fr = (m_ctrl >> 6) & 1;
      oe = (m_ctrl >> 5) & 1;  lv = (m_ctrl >> 4) & 1; cs = m_ctrl & 3;
      case (cs)
        0: tk = 1;
        1: tk = ((m_div % 32) == 31) ? 1 : 0;
        2: tk = (m_div == 127) ? 1 : 0;
        default: tk = (m_s2 == 1 && m_s3 == 0) ? 1 : 0;
      endcase
      case (reg_addr)
        2'd0: m_rdata = m_ctrl | (m_ovf << 3);
        2'd1: m_rdata = m_cmp & 255;
        2'd2: m_rdata = (m_cmp >> 8) & 255;
        default: m_rdata = 0;
      endcase
      m_irq = 0;
      if (run == 0) begin
        m_cnt = 0;
        m_out = (oe == 1 && lv == 1) ? 1 : 0;
      end else begin
        hit = (m_cnt == m_cmp) ? 1 : 0;
        if (tk == 1) begin
          if (fr == 0 && hit == 1) begin
            m_cnt = 0; m_irq = 1;
          end else begin
            if (fr == 1 && m_cnt == 65535) m_ovf = m_ovf ^ 1;
            m_cnt = (m_cnt + 1) % 65536;
          end
        end
        m_out = (oe == 1) ? (m_out ^ (tk & hit)) : 0;
      end
      if (reg_we) begin
        case (reg_addr)
          2'd0: m_ctrl = (run == 0) ? (int'(reg_wdata) & 8'hF3)
                                    : ((m_ctrl & 8'h7F) | (int'(reg_wdata) & 8'h80));
          2'd1: m_cmp = (m_cmp & 16'hFF00) | int'(reg_wdata);
          2'd2: m_cmp = (m_cmp & 16'h00FF) | (int'(reg_wdata) << 8);
          default: ;
        endcase
      end
      m_div = (m_div + 1) % 128;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ev_in);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 count", int'(cnt_o), m_cnt);
      chk("R5 match_irq", int'(match_irq), m_irq);
      chk("R6 ovf_flag", int'(ovf_flag), m_ovf);
      chk("R9 tmr_out", int'(tmr_out), m_out);
      chk("R11 reg_rdata", int'(reg_rdata), m_rdata);
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a);
    reg_addr = a;
    @(negedge clk);
  endtask

  initial begin
    int edges;
    logic [15:0] prev;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 count", int'(cnt_o), 0);
    chk("R1 irq", int'(match_irq), 0);
    chk("R1 ovf", int'(ovf_flag), 0);
    chk("R1 tmr_out", int'(tmr_out), 0);
    chk("R1 ctrl", int'(reg_rdata), 0);
    cmp_on = 1;
    rd(2'd1); chk("R1 cmp low", int'(reg_rdata), 8'hFF);
    rd(2'd2); chk("R1 cmp high", int'(reg_rdata), 8'hFF);
    rd(2'd3); chk("R11 unused addr", int'(reg_rdata), 0);

    // R8 idle level and disabled output
    wr(2'd0, 8'h30); rd(2'd0);
    chk("R8 idle high", int'(tmr_out), 1);
    chk("R11 ctrl readback", int'(reg_rdata), 8'h30);
    wr(2'd0, 8'h20); rd(2'd0);
    chk("R8 idle low", int'(tmr_out), 0);
    wr(2'd0, 8'h0C); rd(2'd0);
    chk("R11 bits 3:2 ignored", int'(reg_rdata), 8'h00);
    chk("R8 output disabled", int'(tmr_out), 0);

    // R3 / R5 / R9 clear-on-match, output toggles
    wr(2'd1, 8'd5); wr(2'd2, 8'd0);
    wr(2'd0, 8'h30); wr(2'd0, 8'hB0);
    repeat (40) @(negedge clk);
    // R12 write while running changes only bit 7
    wr(2'd0, 8'hC3); rd(2'd0);
    chk("R12 running write masked", int'(reg_rdata), 8'hB0);
    wr(2'd0, 8'h00); rd(2'd0);
    chk("R12 stop keeps fields", int'(reg_rdata), 8'h30);
    chk("R2 stopped holds zero", int'(cnt_o), 0);

    // R4 / R6 free-running wraps
    wr(2'd1, 8'h10); wr(2'd2, 8'h00);
    wr(2'd0, 8'h60); wr(2'd0, 8'hE0);
    repeat (65536 + 50) @(negedge clk);
    rd(2'd0); chk("R6 ovf after one wrap", (int'(reg_rdata) >> 3) & 1, 1);
    repeat (65536) @(negedge clk);
    rd(2'd0); chk("R6 ovf after two wraps", (int'(reg_rdata) >> 3) & 1, 0);
    wr(2'd0, 8'h60);

    // R7 prescaler taps
    wr(2'd1, 8'd3); wr(2'd2, 8'd0);
    wr(2'd0, 8'h21); wr(2'd0, 8'hA1);
    repeat (300) @(negedge clk);
    wr(2'd0, 8'h21); wr(2'd0, 8'h22); wr(2'd0, 8'hA2);
    repeat (200) @(negedge clk);
    edges = 0; prev = cnt_o;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      if (cnt_o != prev) edges++;
      prev = cnt_o;
    end
    chk("R7 divide-by-128 tick count", edges, 2);
    wr(2'd0, 8'h22);

    // R10 event input
    wr(2'd1, 8'hFF); wr(2'd2, 8'hFF);
    wr(2'd0, 8'h03); wr(2'd0, 8'h83);
    repeat (4) @(negedge clk);
    ev_in = 1'b1;
    @(negedge clk);
    @(negedge clk); chk("R10 no count before sync", int'(cnt_o), 0);
    @(negedge clk); chk("R10 counts at third edge", int'(cnt_o), 1);
    repeat (5) @(negedge clk);
    chk("R10 held level no recount", int'(cnt_o), 1);
    ev_in = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      ev_in = 1'b1;
      repeat (i % 3 + 1) @(negedge clk);
      ev_in = 1'b0;
      repeat (i % 2 + 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R10 pulse train count", int'(cnt_o), 21);

    cmp_on = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule